// File: doc/BRIEF.md
# Status Register Bit-Manipulation Unit

A small bank of general-purpose status words, each of which can be edited one mask at a time instead of through a full read-modify-write sequence. One operation per cycle names a register, an operation code and a 32-bit operand. Set, clear, toggle and XOR rewrite the chosen word in place. Test compares the word against a mask and latches a one-bit result. Load overwrites the word with the operand.

The read port is combinational: `rdata_o` always shows the current contents of the register that `sel_i` points at. Writes land on the rising clock edge after the operation is presented. The test result is registered on the same edge and holds until the next test. Software or a sequencer uses the unit as scratch space for control and status words before they are passed on elsewhere.

Top module: `ustat_unit`

## Requirements
- R1: After the asynchronous active-low reset, every register reads zero and `test_o` is 0.
- R2: `rdata_o` equals the present contents of the register selected by `sel_i`, with no clock edge needed.
- R3: With `we_i`=1, op code 1 (load) writes `operand_i` into the selected register on the next rising edge.
- R4: With `we_i`=1, op code 2 (set) makes the selected register `old | operand_i`.
- R5: With `we_i`=1, op code 3 (clear) makes the selected register `old & ~operand_i`.
- R6: With `we_i`=1, op codes 4 (toggle) and 5 (XOR) both make the selected register `old ^ operand_i`.
- R7: With `we_i`=1, op code 6 (test) sets `test_o` on the next edge to 1 exactly when every bit that is 1 in `operand_i` is also 1 in the selected register; an all-zero mask gives 1. The register is left unchanged, and `test_o` holds its value until the next test.
- R8: No register changes when `we_i`=0, or when the op code is 0 (no-op) or 7 (reserved), whatever the operand.
- R9: An operation never changes any register other than the one selected by `sel_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_i | input | 3 | Operation code: 0 no-op, 1 load, 2 set, 3 clear, 4 toggle, 5 XOR, 6 test, 7 reserved |
| sel_i | input | 2 | Register select, for both the operation and the read port |
| operand_i | input | 32 | Mask or data operand |
| we_i | input | 1 | Operation enable |
| rdata_o | output | 32 | Contents of the selected register |
| test_o | output | 1 | Result of the most recent test |

## Verification
Every op code is swept across every register with all-zero, all-ones and scattered operands, and each case is repeated with the enable low. After each operation all four registers are read back through the read port. This catches an enable that is ignored, a reserved or no-op code that writes, and a select decode that spills into a neighbouring register.

Clear is checked against registers that are still all ones, so a design that drops the inversion, or that ANDs directly with the operand, returns the wrong word. The test operation is run with a subset mask, a superset mask and the empty mask. A design that tests any-bit-set instead of all-bits-set, writes the register during a test, or clears the flag on later non-test operations reports a wrong flag or a changed register.

// File: rtl/ustat_pkg.sv
package ustat_pkg;
  typedef enum logic [2:0] {
    OP_NOP  = 3'd0,
    OP_LOAD = 3'd1,
    OP_SET  = 3'd2,
    OP_CLR  = 3'd3,
    OP_TGL  = 3'd4,
    OP_XOR  = 3'd5,
    OP_TEST = 3'd6,
    OP_RSV  = 3'd7
  } ustat_op_e;
endpackage

// File: rtl/ustat_alu.sv
module ustat_alu
  import ustat_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  ustat_op_e          op_i,
  input  logic [DATA_W-1:0]  cur_i,
  input  logic [DATA_W-1:0]  opnd_i,
  output logic [DATA_W-1:0]  nxt_o,
  output logic               mod_o,
  output logic               hit_o
);
  always_comb begin
    nxt_o = cur_i;
    mod_o = 1'b1;
    unique case (op_i)
      OP_LOAD:        nxt_o = opnd_i;
      OP_SET:         nxt_o = cur_i | opnd_i;
      OP_CLR:         nxt_o = cur_i & ~opnd_i;
      OP_TGL, OP_XOR: nxt_o = cur_i ^ opnd_i;
      default:        mod_o = 1'b0;
    endcase
  end

  // all masked bits must be one; empty mask passes
  assign hit_o = ((cur_i & opnd_i) == opnd_i);
endmodule

// File: rtl/ustat_bank.sv
module ustat_bank #(
  parameter int NUM_REGS = 4,
  parameter int DATA_W   = 32,
  localparam int SEL_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [SEL_W-1:0]   sel_i,
  input  logic [DATA_W-1:0]  wr_data_i,
  output logic [DATA_W-1:0]  rd_data_o
);
  logic [DATA_W-1:0] regs_q [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                              regs_q[g] <= '0;
      else if (wr_en_i && sel_i == SEL_W'(g))   regs_q[g] <= wr_data_i;
    end
  end

  always_comb begin
    rd_data_o = '0;
    for (int i = 0; i < NUM_REGS; i++)
      if (sel_i == SEL_W'(i)) rd_data_o = regs_q[i];
  end
endmodule

// File: rtl/ustat_flag.sv
module ustat_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ld_i,
  input  logic hit_i,
  output logic flag_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   flag_o <= 1'b0;
    else if (ld_i) flag_o <= hit_i;
  end
endmodule

// File: rtl/ustat_unit.sv
module ustat_unit
  import ustat_pkg::*;
#(
  parameter int NUM_REGS = 4,
  parameter int DATA_W   = 32,
  localparam int SEL_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [2:0]         op_i,
  input  logic [SEL_W-1:0]   sel_i,
  input  logic [DATA_W-1:0]  operand_i,
  input  logic               we_i,
  output logic [DATA_W-1:0]  rdata_o,
  output logic               test_o
);
  ustat_op_e         op;
  logic [DATA_W-1:0] cur, nxt;
  logic              mod, hit;

  assign op = ustat_op_e'(op_i);

  ustat_bank #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_bank (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (we_i && mod),
    .sel_i     (sel_i),
    .wr_data_i (nxt),
    .rd_data_o (cur)
  );

  ustat_alu #(.DATA_W(DATA_W)) u_alu (
    .op_i   (op),
    .cur_i  (cur),
    .opnd_i (operand_i),
    .nxt_o  (nxt),
    .mod_o  (mod),
    .hit_o  (hit)
  );

  ustat_flag u_flag (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ld_i   (we_i && op == OP_TEST),
    .hit_i  (hit),
    .flag_o (test_o)
  );

  assign rdata_o = cur;
endmodule

// File: rtl/ustat_unit_chk.sv
module ustat_unit_chk #(
  parameter int NUM_REGS = 4,
  parameter int DATA_W   = 32,
  localparam int SEL_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [2:0]         op_i,
  input logic [SEL_W-1:0]   sel_i,
  input logic [DATA_W-1:0]  operand_i,
  input logic               we_i,
  input logic [DATA_W-1:0]  rdata_o,
  input logic               test_o
);
  // R3
  load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && op_i == 3'd1) |=> (sel_i != $past(sel_i)) || rdata_o == $past(operand_i));

  // R4
  set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && op_i == 3'd2) |=> (sel_i != $past(sel_i)) || rdata_o == ($past(rdata_o) | $past(operand_i)));

  // R5
  clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && op_i == 3'd3) |=> (sel_i != $past(sel_i)) || rdata_o == ($past(rdata_o) & ~$past(operand_i)));

  // R6
  xor_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && (op_i == 3'd4 || op_i == 3'd5)) |=> (sel_i != $past(sel_i)) || rdata_o == ($past(rdata_o) ^ $past(operand_i)));

  // R7
  test_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && op_i == 3'd6) |=> test_o == (($past(rdata_o) & $past(operand_i)) == $past(operand_i)));

  // R7
  test_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_i && op_i == 3'd6) |=> $stable(test_o));

  // R8
  no_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!we_i || op_i == 3'd0 || op_i == 3'd6 || op_i == 3'd7) |=> (sel_i != $past(sel_i)) || $stable(rdata_o));
endmodule

bind ustat_unit ustat_unit_chk #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .op_i      (op_i),
  .sel_i     (sel_i),
  .operand_i (operand_i),
  .we_i      (we_i),
  .rdata_o   (rdata_o),
  .test_o    (test_o)
);

// File: tb/ustat_unit_tb.sv
`timescale 1ns/100ps
module ustat_unit_tb;
  localparam int N = 4;
  localparam int W = 32;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic [2:0]   op_i = '0;
  logic [1:0]   sel_i = '0;
  logic [W-1:0] operand_i = '0;
  logic         we_i = 1'b0;
  logic [W-1:0] rdata_o;
  logic         test_o;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  logic [W-1:0] exp_r [N];
  logic         exp_f;

  always #4 clk_i = ~clk_i;

  ustat_unit #(.NUM_REGS(N), .DATA_W(W)) u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .op_i(op_i), .sel_i(sel_i),
    .operand_i(operand_i), .we_i(we_i), .rdata_o(rdata_o), .test_o(test_o)
  );

  task automatic chk(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic string op_tag(logic [2:0] op, logic we);
    if (!we) return "R8";
    case (op)
      3'd1: return "R3";
      3'd2: return "R4";
      3'd3: return "R5";
      3'd4, 3'd5: return "R6";
      3'd6: return "R7";
      default: return "R8";
    endcase
  endfunction

  function automatic logic [W-1:0] pat(int k);
    if (k == 0) return '0;
    if (k == 1) return '1;
    return (32'h9E37_79B9 * k) ^ (32'hA5A5_0000 >> k);
  endfunction

  // read every register via the read port; R2 and R9 ride on this
  task automatic check_all(int hot, string tag);
    for (int s = 0; s < N; s++) begin
      sel_i = 2'(s);
      #0.5;
      chk((s == hot) ? tag : "R9", rdata_o, exp_r[s]);
    end
    total++;
    if (test_o !== exp_f) begin
      bad++;
      $display("FAIL R7 test_o act=%b exp=%b", test_o, exp_f);
    end
  endtask

  task automatic apply(logic [2:0] op, int s, logic [W-1:0] opnd, logic we);
    @(negedge clk_i);
    op_i = op; sel_i = 2'(s); operand_i = opnd; we_i = we;
    #0.5;
    chk("R2", rdata_o, exp_r[s]);
    @(negedge clk_i);
    we_i = 1'b0; op_i = 3'd0;
    if (we) begin
      case (op)
        3'd1: exp_r[s] = opnd;
        3'd2: exp_r[s] = exp_r[s] | opnd;
        3'd3: exp_r[s] = exp_r[s] & ~opnd;
        3'd4, 3'd5: exp_r[s] = exp_r[s] ^ opnd;
        3'd6: exp_f = ((exp_r[s] & opnd) == opnd);
        default: ;
      endcase
    end
    check_all(s, op_tag(op, we));
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int s = 0; s < N; s++) exp_r[s] = '0;
    exp_f = 1'b0;
    #20;
    // R1 reset state
    check_all(0, "R1");
    @(negedge clk_i);
    rst_ni = 1'b1;
    check_all(0, "R1");

    // directed test cases: subset, superset, empty mask
    apply(3'd1, 2, 32'h00F0_0F0F, 1'b1);
    apply(3'd6, 2, 32'h0000_0F01, 1'b1);   // R7 subset -> 1
    apply(3'd2, 1, 32'h0000_0001, 1'b1);   // R7 flag holds
    apply(3'd6, 2, 32'h0100_0F0F, 1'b1);   // R7 superset -> 0
    apply(3'd0, 2, 32'hFFFF_FFFF, 1'b1);   // R8 no-op
    apply(3'd6, 3, 32'h0000_0000, 1'b1);   // R7 empty mask -> 1
    apply(3'd6, 2, 32'hFFFF_FFFF, 1'b0);   // R8 disabled test leaves flag
    // R5 clear against all-ones word
    apply(3'd1, 0, 32'hFFFF_FFFF, 1'b1);
    apply(3'd3, 0, 32'h1234_5678, 1'b1);

    // sweep all ops, registers, operands, enable values
    for (int we_v = 1; we_v >= 0; we_v--)
      for (int op = 0; op < 8; op++)
        for (int s = 0; s < N; s++)
          for (int k = 0; k < 6; k++) begin
            apply(3'(op), s, pat(k), we_v[0]);
            if (op == 3'd2 && k == 5) apply(3'd6, s, pat(k), 1'b1);
          end

    // async reset mid-run clears everything (R1)
    @(negedge clk_i);
    rst_ni = 1'b0;
    for (int s = 0; s < N; s++) exp_r[s] = '0;
    exp_f = 1'b0;
    #1;
    check_all(0, "R1");
    rst_ni = 1'b1;

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule